// File: doc/BRIEF.md
# DMA Channel Address and Count Engine

This block is the datapath of a single DMA channel. It holds a page register, a base and current transfer address, a base and current transfer count, a mode register and a channel mask. For every accepted transfer strobe it steps the current address up or down by one, counts the current count down by one and drives a 24-bit physical address for the next transfer cycle. Bus handshaking and the register decode sit outside; this block only sees one write strobe per register.

The channel can work in byte units or in 16-bit word units. In byte units the 16-bit address sits under an 8-bit page. In word units the address is shifted up by one bit, the lowest physical bit is held at zero and the low page bit is dropped. The page is never changed by the counters, so a run of transfers wraps inside its 64 KB (byte) or 128 KB (word) window. A programmed count of N moves N+1 units. When the count steps past zero, terminal count is flagged. The channel then either masks itself or, with auto-initialize, reloads address and count from their base copies and keeps going.

Top module: `dma_xfer_engine`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge) phys_addr and cur_count read 0, chan_masked reads 1 and done_o reads 0.
- R2: With mode bit 2 (word) clear, phys_addr[23:16] equals the page register and phys_addr[15:0] equals the current address.
- R3: With mode bit 2 (word) set, phys_addr[23:17] equals page bits [7:1], phys_addr[16:1] equals the current address, phys_addr[0] is 0, and page bit 0 has no effect.
- R4: An accepted xfer_stb with mode bit 0 (decrement) clear adds one to the current address and subtracts one from cur_count at the same clock edge.
- R5: An accepted xfer_stb with mode bit 0 (decrement) set subtracts one from the current address.
- R6: The current address wraps modulo 2^16 (0xFFFF to 0x0000 and back) and the page part of phys_addr never changes on a strobe.
- R7: tc_o is high during the cycle of an accepted strobe while cur_count is 0x0000; a count of N gives N+1 accepted strobes, and without auto-initialize cur_count then reads 0xFFFF.
- R8: With mode bit 1 (auto-initialize) clear, terminal count sets chan_masked, and later strobes leave address and count unchanged.
- R9: With mode bit 1 (auto-initialize) set, terminal count reloads the current address and count from the base values written last, and chan_masked stays 0.
- R10: A strobe is accepted only while chan_masked is 0; mask_wr loads chan_masked from mask_wdata (1 masks, 0 enables).
- R11: done_o pulses high for exactly the cycle after each terminal count.
- R12: A page write changes only the page field of phys_addr; current address and cur_count keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| page_wr | input | 1 | Load page register |
| page_wdata | input | 8 | Page value |
| addr_wr | input | 1 | Load base and current address |
| addr_wdata | input | 16 | Address value |
| cnt_wr | input | 1 | Load base and current count |
| cnt_wdata | input | 16 | Count value (transfers minus one) |
| mode_wr | input | 1 | Load mode register |
| mode_wdata | input | 3 | bit0 decrement, bit1 auto-initialize, bit2 word units |
| mask_wr | input | 1 | Load channel mask |
| mask_wdata | input | 1 | 1 masks, 0 enables |
| xfer_stb | input | 1 | One transfer completed |
| phys_addr | output | 24 | Physical address of the next transfer |
| cur_count | output | 16 | Current remaining count |
| chan_masked | output | 1 | Channel mask state |
| tc_o | output | 1 | Terminal count, combinational in the strobe cycle |
| done_o | output | 1 | Registered pulse one cycle after terminal count |

## Verification
Address, count, mask and mapping results appear at the clock edge that samples the write or strobe, so each expected item is queued just after that edge and compared at the following falling edge. tc_o is combinational and is checked in the strobe's own cycle, before the edge that consumes the strobe. done_o comes one register later and is checked in the same item as the count that produced the wrap.

// File: rtl/dma_xfer_pkg.sv
// Shared widths and the mode record of the DMA channel engine.
package dma_xfer_pkg;
    localparam int PAGE_W = 8;
    localparam int ADDR_W = 16;
    localparam int CNT_W  = 16;
    localparam int PHYS_W = PAGE_W + ADDR_W;

    // Mode register contents; the write bit positions are set in the top.
    typedef struct packed {
        logic word;
        logic autoinit;
        logic dec;
    } chan_mode_t;
endpackage

// File: rtl/dma_addr_ctr.sv
// Base/current address pair. Assumes load, reload and step are not used to
// express conflicting intent; load wins, then reload, then step.
module dma_addr_ctr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         reload,
    input  logic         step,
    input  logic         dec,
    output logic [W-1:0] cur
);
    logic [W-1:0] base_q;
    logic [W-1:0] cur_q;

    // Hold the base copy and move the current address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            cur_q  <= '0;
        end else if (load) begin
            base_q <= load_val;
            cur_q  <= load_val;
        end else if (reload) begin
            cur_q <= base_q;
        end else if (step) begin
            cur_q <= dec ? cur_q - W'(1) : cur_q + W'(1);
        end
    end

    assign cur = cur_q;
endmodule

// File: rtl/dma_count_ctr.sv
// Base/current count pair counting down. Flags the zero state so the top
// can detect the step past zero. Same priority as the address counter.
module dma_count_ctr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         reload,
    input  logic         step,
    output logic [W-1:0] cur,
    output logic         at_zero
);
    logic [W-1:0] base_q;
    logic [W-1:0] cur_q;

    // Hold the base copy and count the current value down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            cur_q  <= '0;
        end else if (load) begin
            base_q <= load_val;
            cur_q  <= load_val;
        end else if (reload) begin
            cur_q <= base_q;
        end else if (step) begin
            cur_q <= cur_q - W'(1);
        end
    end

    assign cur     = cur_q;
    assign at_zero = (cur_q == '0);
endmodule

// File: rtl/dma_phys_map.sv
// Forms the physical address from page and current address. Byte units put
// the address straight under the page; word units shift it up by one and
// drop the low page bit. Assumes PHYS_W = PAGE_W + ADDR_W.
module dma_phys_map #(
    parameter int PAGE_W = 8,
    parameter int ADDR_W = 16,
    parameter int PHYS_W = PAGE_W + ADDR_W
) (
    input  logic [PAGE_W-1:0] page,
    input  logic [ADDR_W-1:0] addr,
    input  logic              word,
    output logic [PHYS_W-1:0] phys
);
    logic [PHYS_W-1:0] byte_map;
    logic [PHYS_W-1:0] word_map;

    assign byte_map = {page, addr};
    assign word_map = {page[PAGE_W-1:1], addr, 1'b0};

    // Select the mapping for the active unit size.
    always_comb begin
        phys = word ? word_map : byte_map;
    end
endmodule

// File: rtl/dma_xfer_engine.sv
// One DMA channel's address/count engine. Register writes take priority over
// a strobe in the same cycle; a strobe is only accepted while unmasked.
// Terminal count is the accepted strobe seen with the count at zero.
module dma_xfer_engine
    import dma_xfer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              page_wr,
    input  logic [PAGE_W-1:0] page_wdata,
    input  logic              addr_wr,
    input  logic [ADDR_W-1:0] addr_wdata,
    input  logic              cnt_wr,
    input  logic [CNT_W-1:0]  cnt_wdata,
    input  logic              mode_wr,
    input  logic [2:0]        mode_wdata,
    input  logic              mask_wr,
    input  logic              mask_wdata,
    input  logic              xfer_stb,
    output logic [PHYS_W-1:0] phys_addr,
    output logic [CNT_W-1:0]  cur_count,
    output logic              chan_masked,
    output logic              tc_o,
    output logic              done_o
);
    logic [PAGE_W-1:0] page_q;
    chan_mode_t        mode_q;
    logic              mask_q;
    logic              done_q;
    logic [ADDR_W-1:0] cur_addr;
    logic              cnt_zero;
    logic              accept;
    logic              term;
    logic              reload;
    logic              step;

    // Decide whether this cycle's strobe moves the counters.
    always_comb begin
        accept = xfer_stb && !mask_q && !addr_wr && !cnt_wr;
        term   = accept && cnt_zero;
        reload = term && mode_q.autoinit;
        step   = accept && !reload;
    end

    // Page register, written on its own strobe only.
    always_ff @(posedge clk) begin
        if (!rst_n)       page_q <= '0;
        else if (page_wr) page_q <= page_wdata;
    end

    // Mode register: bit0 decrement, bit1 auto-initialize, bit2 word units.
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= '0;
        else if (mode_wr) mode_q <= '{word: mode_wdata[2], autoinit: mode_wdata[1], dec: mode_wdata[0]};
    end

    // Channel mask: software write, or self-mask at a non-reloading terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n)                        mask_q <= 1'b1;
        else if (mask_wr)                  mask_q <= mask_wdata;
        else if (term && !mode_q.autoinit) mask_q <= 1'b1;
    end

    // Completion pulse one cycle after terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= term;
    end

    dma_addr_ctr #(.W(ADDR_W)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (addr_wr),
        .load_val (addr_wdata),
        .reload   (reload),
        .step     (step),
        .dec      (mode_q.dec),
        .cur      (cur_addr)
    );

    dma_count_ctr #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_wr),
        .load_val (cnt_wdata),
        .reload   (reload),
        .step     (step),
        .cur      (cur_count),
        .at_zero  (cnt_zero)
    );

    dma_phys_map #(.PAGE_W(PAGE_W), .ADDR_W(ADDR_W), .PHYS_W(PHYS_W)) u_map (
        .page (page_q),
        .addr (cur_addr),
        .word (mode_q.word),
        .phys (phys_addr)
    );

    assign chan_masked = mask_q;
    assign tc_o        = term;
    assign done_o      = done_q;
endmodule

// File: rtl/dma_xfer_engine_chk.sv
// Temporal checks for the DMA channel engine, bound into every instance.
module dma_xfer_engine_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        page_wr,
    input logic        addr_wr,
    input logic        cnt_wr,
    input logic        mode_wr,
    input logic        mask_wr,
    input logic        xfer_stb,
    input logic        autoinit,
    input logic [23:0] phys_addr,
    input logic [15:0] cur_count,
    input logic        chan_masked,
    input logic        tc_o,
    input logic        done_o
);
    assert_tc_wraps_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_o && !autoinit && !mask_wr) |=> (cur_count == 16'hFFFF));

    assert_self_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_o && !autoinit && !mask_wr) |=> chan_masked);

    assert_auto_stays_open_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_o && autoinit && !mask_wr) |=> !chan_masked);

    assert_masked_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_masked && !cnt_wr) |=> $stable(cur_count));

    assert_done_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
        tc_o |=> done_o);

    assert_done_only_after_tc_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !tc_o |=> !done_o);

    assert_page_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_stb && !page_wr && !mode_wr) |=> $stable(phys_addr[23:17]));

    assert_page_write_keeps_count_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (page_wr && !xfer_stb && !cnt_wr) |=> $stable(cur_count));
endmodule

bind dma_xfer_engine dma_xfer_engine_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .page_wr     (page_wr),
    .addr_wr     (addr_wr),
    .cnt_wr      (cnt_wr),
    .mode_wr     (mode_wr),
    .mask_wr     (mask_wr),
    .xfer_stb    (xfer_stb),
    .autoinit    (mode_q.autoinit),
    .phys_addr   (phys_addr),
    .cur_count   (cur_count),
    .chan_masked (chan_masked),
    .tc_o        (tc_o),
    .done_o      (done_o)
);

// File: tb/dma_xfer_engine_tb_top.sv
`timescale 1ns/1ps
module dma_xfer_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        page_wr = 0, addr_wr = 0, cnt_wr = 0, mode_wr = 0, mask_wr = 0;
    logic [7:0]  page_wdata = 0;
    logic [15:0] addr_wdata = 0, cnt_wdata = 0;
    logic [2:0]  mode_wdata = 0;
    logic        mask_wdata = 0;
    logic        xfer_stb = 0;
    logic [23:0] phys_addr;
    logic [15:0] cur_count;
    logic        chan_masked, tc_o, done_o;

    always #2.5 clk = ~clk;

    dma_xfer_engine dut_i (
        .clk(clk), .rst_n(rst_n),
        .page_wr(page_wr), .page_wdata(page_wdata),
        .addr_wr(addr_wr), .addr_wdata(addr_wdata),
        .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
        .mode_wr(mode_wr), .mode_wdata(mode_wdata),
        .mask_wr(mask_wr), .mask_wdata(mask_wdata),
        .xfer_stb(xfer_stb),
        .phys_addr(phys_addr), .cur_count(cur_count),
        .chan_masked(chan_masked), .tc_o(tc_o), .done_o(done_o)
    );

    typedef struct packed {
        logic [23:0] phys;
        logic [15:0] cnt;
        logic        masked;
        logic        done;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    n_vec = 0;
    int    n_bad = 0;
    bit    finished = 0;

    // Reference state built from the requirements.
    logic [7:0]  m_page = 0;
    logic [15:0] m_base_a = 0, m_cur_a = 0, m_base_c = 0, m_cur_c = 0;
    logic        m_dec = 0, m_auto = 0, m_word = 0, m_mask = 1, m_done = 0;

    function automatic logic [23:0] m_phys();
        if (m_word) return {m_page[7:1], m_cur_a, 1'b0};   // R3
        return {m_page, m_cur_a};                          // R2
    endfunction

    task automatic push(string tag);
        exp_t e;
        e.phys = m_phys(); e.cnt = m_cur_c; e.masked = m_mask; e.done = m_done;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic finish_edge(string tag);
        @(posedge clk);
        #1;
        page_wr = 0; addr_wr = 0; cnt_wr = 0; mode_wr = 0; mask_wr = 0; xfer_stb = 0;
        push(tag);
    endtask

    task automatic wr_page(logic [7:0] v, string tag);
        @(negedge clk); page_wr = 1; page_wdata = v;
        m_page = v; m_done = 0;
        finish_edge(tag);
    endtask

    task automatic wr_addr(logic [15:0] v, string tag);
        @(negedge clk); addr_wr = 1; addr_wdata = v;
        m_base_a = v; m_cur_a = v; m_done = 0;
        finish_edge(tag);
    endtask

    task automatic wr_cnt(logic [15:0] v, string tag);
        @(negedge clk); cnt_wr = 1; cnt_wdata = v;
        m_base_c = v; m_cur_c = v; m_done = 0;
        finish_edge(tag);
    endtask

    task automatic wr_mode(logic word, logic autoi, logic dec, string tag);
        @(negedge clk); mode_wr = 1; mode_wdata = {word, autoi, dec};
        m_word = word; m_auto = autoi; m_dec = dec; m_done = 0;
        finish_edge(tag);
    endtask

    task automatic wr_mask(logic v, string tag);
        @(negedge clk); mask_wr = 1; mask_wdata = v;
        m_mask = v; m_done = 0;
        finish_edge(tag);
    endtask

    // One strobe: tc_o is checked in the strobe cycle, state after the edge.
    task automatic strobe(string tag);
        logic tc;
        @(negedge clk); xfer_stb = 1;
        tc = !m_mask && (m_cur_c == 16'h0000);
        #1;
        n_vec++;
        if (tc_o !== tc) begin
            n_bad++;
            $display("FAIL %s R7 tc_o: actual %0b expected %0b", tag, tc_o, tc);
        end
        if (!m_mask) begin
            if (tc && m_auto) begin                        // R9
                m_cur_a = m_base_a; m_cur_c = m_base_c;
            end else begin
                m_cur_a = m_dec ? m_cur_a - 16'd1 : m_cur_a + 16'd1;  // R4 R5 R6
                m_cur_c = m_cur_c - 16'd1;
                if (tc) m_mask = 1;                        // R8
            end
        end
        m_done = tc;                                       // R11
        finish_edge(tag);
    endtask

    // Monitor: compare each expected item one half-cycle after it is due.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_vec++;
            if ({phys_addr, cur_count, chan_masked, done_o} !== e) begin
                n_bad++;
                $display("FAIL %s: actual phys=%h cnt=%h mask=%b done=%b expected phys=%h cnt=%h mask=%b done=%b",
                         t, phys_addr, cur_count, chan_masked, done_o, e.phys, e.cnt, e.masked, e.done);
            end
        end
    end

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1; rst_n = 1;
        push("R1 reset state");
        // R2 byte mapping, R4 increment
        wr_page(8'h35, "R12 page only");
        wr_addr(16'h1234, "R2 byte map");
        wr_cnt(16'h0002, "R7 count load");
        strobe("R10 masked strobe ignored");
        wr_mask(1'b0, "R10 unmask");
        strobe("R4 step 1");
        strobe("R4 step 2");
        strobe("R7 third strobe is terminal");
        strobe("R8 strobe after self-mask");
        wr_page(8'h36, "R12 page write keeps address and count");
        // R5 decrement and R6 wrap downward
        wr_mode(1'b0, 1'b0, 1'b1, "R5 mode dec");
        wr_addr(16'h0001, "R5 addr");
        wr_cnt(16'h0003, "R5 cnt");
        wr_mask(1'b0, "R5 unmask");
        strobe("R5 dec to 0000");
        strobe("R6 dec wraps to FFFF, page held");
        // R3 word mapping, page bit 0 ignored
        wr_mode(1'b1, 1'b0, 1'b0, "R3 word mode");
        wr_page(8'h37, "R3 page bit0 ignored");
        wr_addr(16'h8000, "R3 word map");
        wr_page(8'h36, "R3 page bit0 cleared same phys");
        // R9 auto-initialize in word units, R6 upward wrap
        wr_mode(1'b1, 1'b1, 1'b0, "R9 auto mode");
        wr_addr(16'hFFFF, "R9 base addr");
        wr_cnt(16'h0001, "R9 base cnt");
        wr_mask(1'b0, "R9 unmask");
        strobe("R6 inc wraps to 0000");
        strobe("R9 terminal reloads");
        strobe("R11 done clears after pulse");
        strobe("R9 second terminal reloads");
        repeat (3) @(posedge clk);
        summary();
    end
endmodule